// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the serial slave that sits in front of a page-buffered flash memory model. It watches a chip-select, a serial clock and a serial data line, all already synchronous to the system clock `clk`. It collects each frame: an 8-bit command code, a 24-bit address, and then as many filler bits as that command needs. After that it either shifts read data out or collects write bytes. The flash array, the page buffer and all self-timed behaviour live outside. They are reached through a read request/response port, a write beat port and an operation launch strobe.

Two command codes map onto each of the four read-type commands. The filler length depends on the command: a main-page or streaming array read waits 32 bits after the address, a buffer read waits 8, and a status read needs neither address nor filler. Program, erase, transfer, compare and rewrite commands only capture an address. Their launch strobe fires when chip-select goes high, and only if the whole address arrived. A buffer write, and a program that goes through the buffer, forward every completed byte to the write port.

The read request port is valid/ready. `rd_valid` holds, with `rd_src`, `rd_page` and `rd_byte` steady, until `rd_ready` is seen high. Every accepted request is answered by exactly one `rd_rsp_valid` beat, which the block always accepts. That beat must arrive before the block needs the byte: half a serial clock after the header ends for the first byte, and within seven serial clock periods for each later byte. The write beat port has no ready signal, because a serial stream cannot be held back; the sink must take every `wr_valid` beat. Launch and status pins are plain levels and strobes.

Top module: `flash_fe_top`

## Requirements
- R1: After `rst_n` is released, `spi_so_oe`, `op_start` and `wr_valid` are 0 and `sck_mode3` is 1.
- R2: At each falling edge of `spi_csn`, `sck_mode3` takes the level of `spi_sck` (0 = idle-low mode 0, 1 = idle-high mode 3). Both modes give the same data, because bits are captured on rising and driven on falling serial clock, and a falling edge seen before the header ends is ignored.
- R3: Status read (code 0x57 or 0xD7) drives, starting with the first falling serial edge after the eighth code bit, the byte {stat_ready, stat_mismatch, 0, 0, 1, 1, 0, 0} MSB first. The byte repeats for as long as the clock runs, and it is taken afresh at the start of each repeat.
- R4: Main page read (0x52 or 0xD2) takes a 24-bit address: bits 23..18 are ignored, bits 17..9 give the page and bits 8..0 give the byte. After 32 filler bits it outputs bytes MSB first from the array (`rd_src`=0), starting at that page and byte. After byte 263 the byte address returns to 0 in the same page.
- R5: Streaming array read (0x68 or 0xE8) is framed as in R4. After byte 263 it moves to byte 0 of the next page, and page 511 is followed by page 0.
- R6: Buffer read (0x54 or 0xD4) takes its start byte from address bits 8..0 and needs 8 filler bits. It reads the buffer (`rd_src`=1), and after byte 263 the address returns to 0.
- R7: Buffer write (0x84) presents each completed byte after the address as one `wr_valid` beat carrying the byte in `wr_data` and its buffer address in `wr_addr`. The address starts at address bits 8..0, counts up and returns to 0 after 263. A trailing partial byte is dropped.
- R8: When `spi_csn` rises after a full address, the codes 0x83, 0x88, 0x81, 0x50, 0x82, 0x53, 0x60 and 0x58 give a one-cycle `op_start` with `op_kind` equal to 0, 1, 2, 3, 4, 5, 6 and 7 respectively. `op_page` is the page field, except that for 0x50 its low three bits are 0, so it names one of 64 blocks of 8 pages. Code 0x82 also forwards its data bytes as in R7.
- R9: If `spi_csn` rises before the 24th address bit, no `op_start` occurs.
- R10: An unrecognised code leaves `spi_so_oe` at 0 for the whole frame, and the frame produces no `wr_valid` and no `op_start`.
- R11: `rst_n` low in the middle of a frame abandons the command: the later `spi_csn` rise launches nothing.
- R12: Once `spi_csn` is high, `spi_so_oe` is 0 from the next clock cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any frame |
| spi_sck | input | 1 | Serial clock, synchronous to clk |
| spi_csn | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Drive enable for spi_so (0 = high impedance) |
| sck_mode3 | output | 1 | Serial clock idle level sampled at frame start |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_src | output | 1 | 0 = array, 1 = buffer |
| rd_page | output | 9 | Read page address |
| rd_byte | output | 9 | Read byte address |
| rd_rsp_valid | input | 1 | Read response beat |
| rd_rsp_data | input | 8 | Read response byte |
| wr_valid | output | 1 | Buffer write beat |
| wr_addr | output | 9 | Buffer byte address of the beat |
| wr_data | output | 8 | Byte of the beat |
| op_start | output | 1 | One-cycle launch of a self-timed operation |
| op_kind | output | 3 | Operation code (see R8) |
| op_page | output | 9 | Target page or block base page |
| stat_ready | input | 1 | Status: memory idle |
| stat_mismatch | input | 1 | Status: last compare differed |

## Verification
On every cycle, the assertions check three things. Launch and write strobes are single-cycle. A launch only appears while chip-select is high, and a write beat only inside a frame. The output driver is off once chip-select is high and is never on for anything but a read or status command. The bench scenarios are what show the data itself: the read byte order, the page and array wraps, the per-command filler length, the block base page, the partial-byte drop, and the effect of a short frame or a reset in mid-frame.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  typedef enum logic [3:0] {
    C_NONE, C_STATUS, C_PGREAD, C_CONT, C_BUFRD, C_BUFWR,
    C_PROG_E, C_PROG_NE, C_PG_ER, C_BLK_ER, C_PROG_THRU,
    C_XFER, C_CMP, C_REWR
  } cmd_e;

  function automatic logic is_read(cmd_e c);
    return (c == C_PGREAD) || (c == C_CONT) || (c == C_BUFRD);
  endfunction

  function automatic logic is_write(cmd_e c);
    return (c == C_BUFWR) || (c == C_PROG_THRU);
  endfunction

  function automatic logic has_addr(cmd_e c);
    return (c != C_NONE) && (c != C_STATUS);
  endfunction

  function automatic logic is_launch(cmd_e c);
    return (c == C_PROG_E) || (c == C_PROG_NE) || (c == C_PG_ER) ||
           (c == C_BLK_ER) || (c == C_PROG_THRU) || (c == C_XFER) ||
           (c == C_CMP) || (c == C_REWR);
  endfunction

  function automatic logic [2:0] kind_of(cmd_e c);
    case (c)
      C_PROG_E:    return 3'd0;
      C_PROG_NE:   return 3'd1;
      C_PG_ER:     return 3'd2;
      C_BLK_ER:    return 3'd3;
      C_PROG_THRU: return 3'd4;
      C_XFER:      return 3'd5;
      C_CMP:       return 3'd6;
      default:     return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/flash_fe_edge.sv
module flash_fe_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;

  for (genvar g = 0; g < N; g++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[g] <= 1'b0;
      else        prev[g] <= sig[g];
    end
    assign rise[g] = sig[g] & ~prev[g];
    assign fall[g] = ~sig[g] & prev[g];
  end
endmodule

// File: rtl/flash_fe_decode.sv
module flash_fe_decode
  import flash_fe_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int ADDR_BITS   = 24,
  parameter int DUMMY_ARRAY = 32,
  parameter int DUMMY_BUF   = 8
) (
  input  logic [7:0]       opc,
  output cmd_e             cmd,
  output logic [CNT_W-1:0] hdr
);
  localparam int HDR_ADDR = 8 + ADDR_BITS;

  always_comb begin
    case (opc)
      8'h57, 8'hD7: cmd = C_STATUS;
      8'h52, 8'hD2: cmd = C_PGREAD;
      8'h68, 8'hE8: cmd = C_CONT;
      8'h54, 8'hD4: cmd = C_BUFRD;
      8'h84:        cmd = C_BUFWR;
      8'h83:        cmd = C_PROG_E;
      8'h88:        cmd = C_PROG_NE;
      8'h81:        cmd = C_PG_ER;
      8'h50:        cmd = C_BLK_ER;
      8'h82:        cmd = C_PROG_THRU;
      8'h53:        cmd = C_XFER;
      8'h60:        cmd = C_CMP;
      8'h58:        cmd = C_REWR;
      default:      cmd = C_NONE;
    endcase
  end

  always_comb begin
    case (cmd)
      C_NONE, C_STATUS: hdr = CNT_W'(8);
      C_PGREAD, C_CONT: hdr = CNT_W'(HDR_ADDR + DUMMY_ARRAY);
      C_BUFRD:          hdr = CNT_W'(HDR_ADDR + DUMMY_BUF);
      default:          hdr = CNT_W'(HDR_ADDR);
    endcase
  end
endmodule

// File: rtl/flash_fe_addr_step.sv
module flash_fe_addr_step #(
  parameter int PAGE_BITS  = 9,
  parameter int BYTE_BITS  = 9,
  parameter int PAGE_BYTES = 264
) (
  input  logic [PAGE_BITS-1:0] page,
  input  logic [BYTE_BITS-1:0] byte_a,
  input  logic                 cross_page,
  output logic [PAGE_BITS-1:0] nxt_page,
  output logic [BYTE_BITS-1:0] nxt_byte
);
  localparam logic [BYTE_BITS-1:0] LAST = BYTE_BITS'(PAGE_BYTES - 1);

  always_comb begin
    nxt_page = page;
    if (byte_a == LAST) begin
      nxt_byte = '0;
      if (cross_page) nxt_page = page + PAGE_BITS'(1);
    end else begin
      nxt_byte = byte_a + BYTE_BITS'(1);
    end
  end
endmodule

// File: rtl/flash_fe_top.sv
module flash_fe_top
  import flash_fe_pkg::*;
#(
  parameter int         PAGE_BITS   = 9,
  parameter int         BYTE_BITS   = 9,
  parameter int         PAGE_BYTES  = 264,
  parameter int         ADDR_BITS   = 24,
  parameter int         DUMMY_ARRAY = 32,
  parameter int         DUMMY_BUF   = 8,
  parameter int         BLOCK_SHIFT = 3,
  parameter logic [3:0] DENSITY     = 4'b0011
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sck,
  input  logic                 spi_csn,
  input  logic                 spi_si,
  output logic                 spi_so,
  output logic                 spi_so_oe,
  output logic                 sck_mode3,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic                 rd_src,
  output logic [PAGE_BITS-1:0] rd_page,
  output logic [BYTE_BITS-1:0] rd_byte,
  input  logic                 rd_rsp_valid,
  input  logic [7:0]           rd_rsp_data,
  output logic                 wr_valid,
  output logic [BYTE_BITS-1:0] wr_addr,
  output logic [7:0]           wr_data,
  output logic                 op_start,
  output logic [2:0]           op_kind,
  output logic [PAGE_BITS-1:0] op_page,
  input  logic                 stat_ready,
  input  logic                 stat_mismatch
);
  localparam int CNT_W = $clog2(8 + ADDR_BITS + DUMMY_ARRAY + 1);
  localparam int SH_W  = PAGE_BITS + BYTE_BITS - 1;
  localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS + 7);

  logic [1:0] e_rise, e_fall;
  logic       sck_rise, sck_fall, cs_rise, cs_fall;

  flash_fe_edge #(.N(2)) edge_i (
    .clk(clk), .rst_n(rst_n), .sig({spi_csn, spi_sck}),
    .rise(e_rise), .fall(e_fall)
  );
  assign sck_rise = e_rise[0];
  assign sck_fall = e_fall[0];
  assign cs_rise  = e_rise[1];
  assign cs_fall  = e_fall[1];

  logic             active, addr_done, data_ph, req_pend, so_oe;
  cmd_e             cmd, dec_cmd;
  logic [CNT_W-1:0] bitcnt, hdr_len, dec_hdr, hdr_last;
  logic [SH_W-1:0]  shreg;
  logic [PAGE_BITS-1:0] cur_page, nxt_page;
  logic [BYTE_BITS-1:0] cur_byte, nxt_byte;
  logic [2:0]       obit, wbit;
  logic [7:0]       so_sr, fetched, status_byte;
  logic [6:0]       wsr;

  flash_fe_decode #(
    .CNT_W(CNT_W), .ADDR_BITS(ADDR_BITS),
    .DUMMY_ARRAY(DUMMY_ARRAY), .DUMMY_BUF(DUMMY_BUF)
  ) dec_i (
    .opc({shreg[6:0], spi_si}), .cmd(dec_cmd), .hdr(dec_hdr)
  );

  flash_fe_addr_step #(
    .PAGE_BITS(PAGE_BITS), .BYTE_BITS(BYTE_BITS), .PAGE_BYTES(PAGE_BYTES)
  ) step_i (
    .page(cur_page), .byte_a(cur_byte), .cross_page(cmd == C_CONT),
    .nxt_page(nxt_page), .nxt_byte(nxt_byte)
  );

  assign hdr_last    = hdr_len - CNT_W'(1);
  assign status_byte = {stat_ready, stat_mismatch, DENSITY, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      addr_done <= 1'b0;
      data_ph   <= 1'b0;
      req_pend  <= 1'b0;
      so_oe     <= 1'b0;
      sck_mode3 <= 1'b1;
      cmd       <= C_NONE;
      bitcnt    <= '0;
      hdr_len   <= '1;
      shreg     <= '0;
      cur_page  <= '0;
      cur_byte  <= '0;
      obit      <= '0;
      wbit      <= '0;
      so_sr     <= '0;
      fetched   <= '0;
      wsr       <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      op_start  <= 1'b0;
      op_kind   <= '0;
      op_page   <= '0;
    end else begin
      op_start <= 1'b0;
      wr_valid <= 1'b0;
      if (req_pend && rd_ready) req_pend <= 1'b0;
      if (rd_rsp_valid) fetched <= rd_rsp_data;

      if (cs_fall) begin
        active    <= 1'b1;
        addr_done <= 1'b0;
        data_ph   <= 1'b0;
        req_pend  <= 1'b0;
        so_oe     <= 1'b0;
        sck_mode3 <= spi_sck;
        cmd       <= C_NONE;
        bitcnt    <= '0;
        hdr_len   <= '1;
        obit      <= '0;
        wbit      <= '0;
      end else if (cs_rise) begin
        active   <= 1'b0;
        data_ph  <= 1'b0;
        req_pend <= 1'b0;
        so_oe    <= 1'b0;
        if (active && addr_done && is_launch(cmd)) begin
          op_start <= 1'b1;
          op_kind  <= kind_of(cmd);
          op_page  <= (cmd == C_BLK_ER) ?
                      {cur_page[PAGE_BITS-1:BLOCK_SHIFT], BLOCK_SHIFT'(0)} : cur_page;
        end
      end else if (active && sck_rise) begin
        if (!data_ph) begin
          shreg <= {shreg[SH_W-2:0], spi_si};
          if (bitcnt != hdr_len) bitcnt <= bitcnt + CNT_W'(1);
          if (bitcnt == OPC_LAST) begin
            cmd     <= dec_cmd;
            hdr_len <= dec_hdr;
            if (dec_cmd == C_STATUS) data_ph <= 1'b1;
          end
          if (bitcnt == ADDR_LAST && has_addr(cmd)) begin
            addr_done <= 1'b1;
            cur_page  <= shreg[BYTE_BITS-1 +: PAGE_BITS];
            cur_byte  <= {shreg[BYTE_BITS-2:0], spi_si};
          end
          if (bitcnt == hdr_last && bitcnt > OPC_LAST && has_addr(cmd)) begin
            data_ph <= 1'b1;
            if (is_read(cmd)) req_pend <= 1'b1;
          end
        end else if (is_write(cmd)) begin
          wsr  <= {wsr[5:0], spi_si};
          wbit <= wbit + 3'd1;
          if (wbit == 3'd7) begin
            wr_valid <= 1'b1;
            wr_addr  <= cur_byte;
            wr_data  <= {wsr, spi_si};
            cur_byte <= nxt_byte;
          end
        end
      end else if (active && sck_fall && data_ph &&
                   (is_read(cmd) || cmd == C_STATUS)) begin
        so_oe <= 1'b1;
        obit  <= obit + 3'd1;
        if (obit == 3'd0) begin
          if (cmd == C_STATUS) begin
            so_sr <= status_byte;
          end else begin
            so_sr    <= fetched;
            cur_page <= nxt_page;
            cur_byte <= nxt_byte;
            req_pend <= 1'b1;
          end
        end else begin
          so_sr <= {so_sr[6:0], 1'b0};
        end
      end
    end
  end

  assign spi_so    = so_sr[7];
  assign spi_so_oe = so_oe;
  assign rd_valid  = req_pend;
  assign rd_src    = (cmd == C_BUFRD);
  assign rd_page   = cur_page;
  assign rd_byte   = cur_byte;

  // R8: launch is a single-cycle strobe seen with chip select high
  p_op_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> spi_csn);
  p_op_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);
  // R7: write beats come from inside a frame, one cycle each
  p_wr_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(!spi_csn));
  p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R12: driver off while deselected
  p_oe_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn)) |-> !spi_so_oe);
  // R10: driver only for decoded read or status commands
  p_oe_readcmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_so_oe |-> (is_read(cmd) || cmd == C_STATUS));
endmodule

// File: tb/flash_fe_top_tb_top.sv
module flash_fe_top_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, sck = 1'b0, csn = 1'b1, si = 1'b0;
  logic so, so_oe, mode3, rd_valid, rd_src, rsp_v = 1'b0;
  logic [8:0] rd_page, rd_byte, wr_addr, op_page;
  logic [7:0] rsp_d = 8'h00, wr_data;
  logic wr_valid, op_start, rd_ready;
  logic [2:0] op_kind;
  logic stat_ready = 1'b1, stat_mis = 1'b1;
  int cyc = 0;

  flash_fe_top dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_si(si),
    .spi_so(so), .spi_so_oe(so_oe), .sck_mode3(mode3),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_src(rd_src),
    .rd_page(rd_page), .rd_byte(rd_byte),
    .rd_rsp_valid(rsp_v), .rd_rsp_data(rsp_d),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_start(op_start), .op_kind(op_kind), .op_page(op_page),
    .stat_ready(stat_ready), .stat_mismatch(stat_mis)
  );

  function automatic logic [7:0] exp_byte(logic src, logic [8:0] pg, logic [8:0] by);
    if (src) return by[7:0] ^ 8'hC3 ^ {7'b0, by[8]};
    return (by[7:0] + pg[7:0] * 8'd3 + {pg[8], 7'b0}) ^ 8'h5A;
  endfunction

  // memory model with stalls on the request port
  assign rd_ready = (cyc % 3) != 0;
  always @(posedge clk) begin
    cyc   <= cyc + 1;
    rsp_v <= 1'b0;
    if (rd_valid && rd_ready) begin
      rsp_v <= 1'b1;
      rsp_d <= exp_byte(rd_src, rd_page, rd_byte);
    end
  end

  int op_cnt = 0, wcnt = 0;
  logic [2:0] last_kind;
  logic [8:0] last_page;
  logic [8:0] wa [8];
  logic [7:0] wd [8];
  logic oe_seen = 1'b0;
  always @(negedge clk) begin
    if (op_start) begin op_cnt++; last_kind = op_kind; last_page = op_page; end
    if (wr_valid && wcnt < 8) begin wa[wcnt] = wr_addr; wd[wcnt] = wr_data; wcnt++; end
    if (so_oe) oe_seen = 1'b1;
  end

  int total = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cs_start(bit m3);
    sck = m3;
    repeat (4) @(negedge clk);
    csn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_end(bit m3);
    if (!m3) begin sck = 1'b0; repeat (HALF) @(negedge clk); end
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic bit_x(logic v, output logic o, output logic oe);
    si = v;
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    o = so; oe = so_oe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send(logic [63:0] v, int n);
    logic o, oe;
    for (int i = n - 1; i >= 0; i--) bit_x(v[i], o, oe);
  endtask

  task automatic recv32(output logic [31:0] d, output bit oe_all);
    logic o, oe;
    oe_all = 1'b1;
    for (int i = 31; i >= 0; i--) begin
      bit_x(1'b0, o, oe);
      d[i] = o;
      if (!oe) oe_all = 1'b0;
    end
  endtask

  // opcode, page, byte, mode3, spare
  localparam logic [35:0] VECS [0:7] = '{
    {8'h52, 9'd5,   9'd10,  1'b0, 9'd0},
    {8'hD2, 9'd7,   9'd262, 1'b1, 9'd0},
    {8'h68, 9'd9,   9'd262, 1'b0, 9'd0},
    {8'hE8, 9'd511, 9'd263, 1'b1, 9'd0},
    {8'h54, 9'd0,   9'd100, 1'b0, 9'd0},
    {8'hD4, 9'd0,   9'd262, 1'b1, 9'd0},
    {8'h57, 9'd0,   9'd0,   1'b0, 9'd0},
    {8'hD7, 9'd0,   9'd0,   1'b1, 9'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, exp;
    bit oe_all;
    int o0, w0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(so_oe == 1'b0, "R1 oe after reset", so_oe, 0);
    check(mode3 == 1'b1, "R1 mode after reset", mode3, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(op_cnt == 0 && wcnt == 0, "R1 no strobes", op_cnt + wcnt, 0);

    // table of read frames: R2 R3 R4 R5 R6 R12
    for (int v = 0; v < 8; v++) begin
      logic [7:0] opc;
      logic [8:0] pg, by;
      logic m3, src;
      int dmy;
      opc = VECS[v][35:28]; pg = VECS[v][27:19]; by = VECS[v][18:10]; m3 = VECS[v][9];
      src = (opc == 8'h54 || opc == 8'hD4);
      dmy = (opc == 8'h52 || opc == 8'hD2 || opc == 8'h68 || opc == 8'hE8) ? 32 :
            (src ? 8 : 0);
      cs_start(m3);
      check(mode3 == m3, "R2 mode sample", mode3, m3);
      send({56'h0, opc}, 8);
      if (opc != 8'h57 && opc != 8'hD7) begin
        send({40'h0, 6'b0, pg, by}, 24);
        send(64'h0, dmy);
      end
      recv32(got, oe_all);
      for (int k = 0; k < 4; k++) begin
        if (opc == 8'h57 || opc == 8'hD7) exp[31-8*k -: 8] = {stat_ready, stat_mis, 6'b001100};
        else begin
          exp[31-8*k -: 8] = exp_byte(src, pg, by);
          if (by == 9'd263) begin
            by = 9'd0;
            if (opc == 8'h68 || opc == 8'hE8) pg = pg + 9'd1;
          end else by = by + 9'd1;
        end
      end
      check(got == exp && oe_all,
            (opc == 8'h57 || opc == 8'hD7) ? "R3 status stream" :
            (src ? "R6 buffer read" :
            ((opc == 8'h68 || opc == 8'hE8) ? "R5 stream read" : "R4 page read")),
            got, exp);
      cs_end(m3);
      check(so_oe == 1'b0, "R12 oe off after deselect", so_oe, 0);
    end

    // R7: buffer write with wrap and partial byte
    w0 = wcnt;
    cs_start(1'b0);
    send(64'h84, 8);
    send({40'h0, 15'h7FFF, 9'd262}, 24);
    send({40'h0, 8'hA5, 8'h3C, 8'h0F}, 24);
    send(64'h9, 4);
    cs_end(1'b0);
    check(wcnt - w0 == 3, "R7 beat count", wcnt - w0, 3);
    check(wa[0] == 9'd262 && wa[1] == 9'd263 && wa[2] == 9'd0 &&
          wd[0] == 8'hA5 && wd[1] == 8'h3C && wd[2] == 8'h0F,
          "R7 beat addr/data", {wa[2], wd[2]}, {9'd0, 8'h0F});

    // R8: launches
    o0 = op_cnt;
    cs_start(1'b1);
    send({32'h0, 8'h83, 6'b0, 9'd300, 9'd17}, 32);
    cs_end(1'b1);
    check(op_cnt == o0 + 1 && last_kind == 3'd0 && last_page == 9'd300,
          "R8 program launch", last_page, 300);
    cs_start(1'b0);
    send({32'h0, 8'h50, 6'b0, 9'h1AF, 9'd0}, 32);
    cs_end(1'b0);
    check(op_cnt == o0 + 2 && last_kind == 3'd3 && last_page == 9'h1A8,
          "R8 block erase base", last_page, 9'h1A8);
    wcnt = 0;
    cs_start(1'b0);
    send({32'h0, 8'h82, 6'b0, 9'd40, 9'd5}, 32);
    send({48'h0, 8'h11, 8'h22}, 16);
    cs_end(1'b0);
    check(op_cnt == o0 + 3 && last_kind == 3'd4 && last_page == 9'd40,
          "R8 program through buffer launch", last_kind, 4);
    check(wcnt == 2 && wa[0] == 9'd5 && wa[1] == 9'd6 && wd[0] == 8'h11 && wd[1] == 8'h22,
          "R8 program through buffer beats", wcnt, 2);

    // R9: short address
    o0 = op_cnt;
    cs_start(1'b0);
    send({56'h0, 8'h81}, 8);
    send(64'h3FF, 10);
    cs_end(1'b0);
    check(op_cnt == o0, "R9 short frame no launch", op_cnt - o0, 0);

    // R10: unknown code
    o0 = op_cnt; w0 = wcnt; oe_seen = 1'b0;
    cs_start(1'b1);
    send({56'h0, 8'hAB}, 8);
    send(64'hFFFF_FFFF_FF, 40);
    cs_end(1'b1);
    check(!oe_seen && op_cnt == o0 && wcnt == w0, "R10 unknown code ignored",
          oe_seen, 0);

    // R11: reset in mid-frame
    o0 = op_cnt;
    cs_start(1'b0);
    send({32'h0, 8'h83, 6'b0, 9'd100, 9'd0}, 32);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mode3 == 1'b1, "R1 mode after mid-frame reset", mode3, 1);
    cs_end(1'b0);
    check(op_cnt == o0, "R11 aborted command not launched", op_cnt - o0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule